// File: doc/BRIEF.md
# Serial Channel Mode Router

This block sits between the host side of a serial port and its datapath. It decides where each byte goes. A byte can come from the receive line, or from a host write to the data register. It can go to the transmit queue, to the receive queue, to both, or nowhere. The choice depends on a two-bit channel mode: normal, automatic echo, local loopback or remote loopback. The block itself holds no data storage. It only emits enqueue strobes with their bytes, one cycle after the source strobe.

The block also owns the control register. That register holds one enable bit and one disable bit for each direction, two reset request bits that clear themselves, and a start/stop pair for a line break. A small sequencer has two states, `CTL_IDLE` and `CTL_PULSE`. A control write takes it from `CTL_IDLE` to `CTL_PULSE` (transition "write"). In `CTL_PULSE` it emits the requested reset pulses and clears the request bits. It then returns to `CTL_IDLE` (transition "expire"), unless a new write arrives in that cycle (transition "rewrite", which stays in `CTL_PULSE`).

A received line break counts as a 0x00 byte for the receive queue. It is never echoed.

Top module: `urt_mode_router`

## Requirements
- R1: After reset `ctl_q` reads 0x128. Both directions are inactive, `brk_req` is 0, and no push or reset pulse is asserted.
- R2: The receive direction is active when `ctl_q[2]` (enable) is 1 and `ctl_q[3]` (disable) is 0. The transmit direction is active when `ctl_q[4]` (enable) is 1 and `ctl_q[5]` (disable) is 0. When both bits of a pair are set, the direction is off.
- R3: A control write with bit 0 set gives `rx_rst_pulse` high for exactly the cycle after the write. Bit 1 does the same for `tx_rst_pulse`. One cycle later both bits read 0 in `ctl_q`, and the other bits keep the written value.
- R4: `brk_req` is 1 only while `ctl_q[7]` (start break) is 1 and `ctl_q[8]` (stop break) is 0.
- R5: `chan_mode` is encoded as 0 = normal, 1 = echo, 2 = local loopback, 3 = remote loopback. A line byte is pushed to the receive queue in modes 0 and 1. It is pushed to the transmit queue in modes 1 and 3. Each push comes one cycle after `line_vld`, carrying the same byte.
- R6: A host data write is pushed to the transmit queue in mode 0 and to the receive queue in mode 2. It is discarded in modes 1 and 3.
- R7: A push happens only if its target direction was active in the cycle of the source strobe. A control write in that same cycle affects only later strobes.
- R8: `line_brk` pushes 0x00 to the receive queue in modes 0 and 1 when receive is active. It is not echoed to transmit. If `line_vld` is asserted in the same cycle, the line byte wins and the break is dropped. In modes 2 and 3 the break is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mode | input | 2 | Channel mode field |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 9 | Control register write value |
| ctl_q | output | 9 | Control register read value |
| rx_active | output | 1 | Receive direction active |
| tx_active | output | 1 | Transmit direction active |
| line_vld | input | 1 | Byte received from line |
| line_byte | input | 8 | Received byte |
| line_brk | input | 1 | Break received from line |
| host_we | input | 1 | Host write to data register |
| host_byte | input | 8 | Host write byte |
| tx_push | output | 1 | Transmit queue enqueue strobe |
| tx_byte | output | 8 | Transmit queue byte |
| rx_push | output | 1 | Receive queue enqueue strobe |
| rx_byte | output | 8 | Receive queue byte |
| rx_rst_pulse | output | 1 | Receive path reset pulse |
| tx_rst_pulse | output | 1 | Transmit path reset pulse |
| brk_req | output | 1 | Break transmit request |

## Verification
A control write and a data strobe can land in the same cycle. This is the case that matters most. The bench provokes it in two ways. It enables both directions while a line byte arrives, and it disables both directions while another byte arrives. Each time it expects the routing to follow the control value held before the write. The bench also collides `line_brk` with `line_vld` and expects only the line byte to reach the receive queue.

// File: rtl/urt_router_pkg.sv
package urt_router_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ECHO   = 2'd1,
        MODE_LLOOP  = 2'd2,
        MODE_RLOOP  = 2'd3
    } chan_mode_e;

    typedef enum logic {
        CTL_IDLE  = 1'b0,
        CTL_PULSE = 1'b1
    } ctl_state_e;

    // control bit positions
    localparam int unsigned CB_RX_RST = 0;
    localparam int unsigned CB_TX_RST = 1;
    localparam int unsigned CB_EN0    = 2;   // enable of direction d at CB_EN0 + 2*d
    localparam int unsigned CB_BRK_ON = 7;
    localparam int unsigned CB_BRK_OFF = 8;

endpackage

// File: rtl/urt_ctl_seq.sv
module urt_ctl_seq
    import urt_router_pkg::*;
#(
    parameter int unsigned CTL_W   = 9,
    parameter logic [CTL_W-1:0] CTL_RST = 9'h128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic [1:0]       dir_act,
    output logic             rx_rst_pulse,
    output logic             tx_rst_pulse,
    output logic             brk_req
);

    localparam int unsigned NUM_DIR = 2;

    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE:  state_d = ctl_we ? CTL_PULSE : CTL_IDLE;
            CTL_PULSE: state_d = ctl_we ? CTL_PULSE : CTL_IDLE;
            default:   state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata;
        end else if (state_q == CTL_PULSE) begin
            ctl_q[CB_RX_RST] <= 1'b0;
            ctl_q[CB_TX_RST] <= 1'b0;
        end
    end

    always_comb begin
        rx_rst_pulse = (state_q == CTL_PULSE) && ctl_q[CB_RX_RST];
        tx_rst_pulse = (state_q == CTL_PULSE) && ctl_q[CB_TX_RST];
        brk_req      = ctl_q[CB_BRK_ON] && !ctl_q[CB_BRK_OFF];
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam int unsigned EN_B  = CB_EN0 + 2 * d;
        localparam int unsigned DIS_B = EN_B + 1;
        assign dir_act[d] = ctl_q[EN_B] && !ctl_q[DIS_B];
    end

endmodule

// File: rtl/urt_route.sv
module urt_route
    import urt_router_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] BRK_BYTE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_mode,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              line_vld,
    input  logic [DATA_W-1:0] line_byte,
    input  logic              line_brk,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_byte,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_byte,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_byte
);

    chan_mode_e  mode;
    logic        rx_go, tx_go;
    logic [DATA_W-1:0] rx_val, tx_val;

    assign mode = chan_mode_e'(chan_mode);

    always_comb begin
        rx_go  = 1'b0;
        tx_go  = 1'b0;
        rx_val = line_byte;
        tx_val = line_byte;
        unique case (mode)
            MODE_NORMAL: begin
                rx_go  = line_vld || line_brk;
                rx_val = line_vld ? line_byte : BRK_BYTE;
                tx_go  = host_we;
                tx_val = host_byte;
            end
            MODE_ECHO: begin
                rx_go  = line_vld || line_brk;
                rx_val = line_vld ? line_byte : BRK_BYTE;
                tx_go  = line_vld;
            end
            MODE_LLOOP: begin
                rx_go  = host_we;
                rx_val = host_byte;
            end
            MODE_RLOOP: begin
                tx_go  = line_vld;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_push <= 1'b0;
            tx_push <= 1'b0;
            rx_byte <= '0;
            tx_byte <= '0;
        end else begin
            rx_push <= rx_go && rx_active;
            tx_push <= tx_go && tx_active;
            if (rx_go) rx_byte <= rx_val;
            if (tx_go) tx_byte <= tx_val;
        end
    end

endmodule

// File: rtl/urt_mode_router.sv
module urt_mode_router
    import urt_router_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTL_W  = 9,
    parameter logic [CTL_W-1:0] CTL_RST = 9'h128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_mode,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              rx_active,
    output logic              tx_active,
    input  logic              line_vld,
    input  logic [DATA_W-1:0] line_byte,
    input  logic              line_brk,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_byte,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_byte,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_rst_pulse,
    output logic              tx_rst_pulse,
    output logic              brk_req
);

    logic [1:0] dir_act;

    urt_ctl_seq #(.CTL_W(CTL_W), .CTL_RST(CTL_RST)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_we       (ctl_we),
        .ctl_wdata    (ctl_wdata),
        .ctl_q        (ctl_q),
        .dir_act      (dir_act),
        .rx_rst_pulse (rx_rst_pulse),
        .tx_rst_pulse (tx_rst_pulse),
        .brk_req      (brk_req)
    );

    assign rx_active = dir_act[0];
    assign tx_active = dir_act[1];

    urt_route #(.DATA_W(DATA_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_mode (chan_mode),
        .rx_active (rx_active),
        .tx_active (tx_active),
        .line_vld  (line_vld),
        .line_byte (line_byte),
        .line_brk  (line_brk),
        .host_we   (host_we),
        .host_byte (host_byte),
        .tx_push   (tx_push),
        .tx_byte   (tx_byte),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte)
    );

endmodule

// File: rtl/urt_router_chk.sv
module urt_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] chan_mode,
    input logic       ctl_we,
    input logic [8:0] ctl_q,
    input logic       rx_active,
    input logic       tx_active,
    input logic       line_vld,
    input logic [7:0] line_byte,
    input logic       line_brk,
    input logic       host_we,
    input logic       tx_push,
    input logic       rx_push,
    input logic [7:0] rx_byte,
    input logic       rx_rst_pulse
);

    a_r3_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_pulse |-> $past(ctl_we));

    a_r3_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_pulse && !ctl_we |=> !ctl_q[0]);

    a_r5_line_to_rx: assert property (@(posedge clk) disable iff (!rst_n)
        line_vld && rx_active && (chan_mode == 2'd0 || chan_mode == 2'd1)
        |=> rx_push && rx_byte == $past(line_byte));

    a_r6_remote_drops_host: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && !line_vld && chan_mode == 2'd3 |=> !tx_push && !rx_push);

    a_r7_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(rx_active));

    a_r7_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(tx_active));

    a_r8_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
        line_brk && !line_vld && rx_active && chan_mode == 2'd0
        |=> rx_push && rx_byte == 8'h00);

endmodule

bind urt_mode_router urt_router_chk u_chk (.*);

// File: tb/test_urt_mode_router.sv
module test_urt_mode_router;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chan_mode = 2'd0;
    logic       ctl_we = 1'b0;
    logic [8:0] ctl_wdata = '0;
    logic [8:0] ctl_q;
    logic       rx_active, tx_active;
    logic       line_vld = 1'b0;
    logic [7:0] line_byte = '0;
    logic       line_brk = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_byte = '0;
    logic       tx_push, rx_push;
    logic [7:0] tx_byte, rx_byte;
    logic       rx_rst_pulse, tx_rst_pulse, brk_req;

    int total = 0;
    int bad = 0;

    logic [7:0] q_tx[$];
    logic [7:0] q_rx[$];
    logic [8:0] bctl = 9'h128;
    logic       chk_pulse = 1'b0;
    logic [1:0] exp_pulse = 2'b00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    urt_mode_router i_urt_mode_router (
        .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .rx_active(rx_active), .tx_active(tx_active),
        .line_vld(line_vld), .line_byte(line_byte), .line_brk(line_brk),
        .host_we(host_we), .host_byte(host_byte),
        .tx_push(tx_push), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
        .brk_req(brk_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; expectations use the control value before this cycle's write
    task automatic step(input bit cwe, input logic [8:0] cw, input logic [1:0] m,
                        input bit lv, input logic [7:0] lb, input bit brk,
                        input bit hw, input logic [7:0] hb);
        bit ra, ta;
        @(negedge clk);
        chan_mode = m; ctl_we = cwe; ctl_wdata = cw;
        line_vld = lv; line_byte = lb; line_brk = brk;
        host_we = hw; host_byte = hb;
        ra = bctl[2] && !bctl[3];
        ta = bctl[4] && !bctl[5];
        @(posedge clk);
        #1;
        ctl_we = 0; line_vld = 0; line_brk = 0; host_we = 0;
        // R5 / R8: line and break routing
        if ((m == 2'd0 || m == 2'd1) && ra) begin
            if (lv) q_rx.push_back(lb);
            else if (brk) q_rx.push_back(8'h00);
        end
        if ((m == 2'd1 || m == 2'd3) && ta && lv) q_tx.push_back(lb);
        // R6: host routing
        if (m == 2'd0 && ta && hw) q_tx.push_back(hb);
        if (m == 2'd2 && ra && hw) q_rx.push_back(hb);
        if (cwe) begin
            chk_pulse = 1'b1;
            exp_pulse = cw[1:0];
            bctl = cw;
        end else begin
            bctl[1:0] = 2'b00;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, chan_mode, 0, '0, 0, 0, '0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_push) begin
                if (q_tx.size() == 0) check(0, "R5/R6/R7 unexpected tx_push", tx_byte, 0);
                else begin
                    logic [7:0] e;
                    e = q_tx.pop_front();
                    check(tx_byte == e, "R5/R6 tx_byte", tx_byte, e);
                end
            end
            if (rx_push) begin
                if (q_rx.size() == 0) check(0, "R5/R6/R7/R8 unexpected rx_push", rx_byte, 0);
                else begin
                    logic [7:0] e;
                    e = q_rx.pop_front();
                    check(rx_byte == e, "R5/R6/R8 rx_byte", rx_byte, e);
                end
            end
            if (chk_pulse) begin
                check({tx_rst_pulse, rx_rst_pulse} == exp_pulse, "R3 reset pulses",
                      {tx_rst_pulse, rx_rst_pulse}, exp_pulse);
                chk_pulse = 1'b0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(ctl_q == 9'h128, "R1 ctl_q", ctl_q, 9'h128);
        check(!rx_active && !tx_active, "R1 directions", {rx_active, tx_active}, 0);
        check(!brk_req && !tx_push && !rx_push && !rx_rst_pulse && !tx_rst_pulse,
              "R1 outputs", {brk_req, tx_push, rx_push}, 0);
        rst_n = 1'b1;

        // R7: disabled after reset, nothing routed
        step(0, '0, 2'd0, 1, 8'h11, 0, 1, 8'h12);
        // R7 same cycle: enable written with a line byte, byte dropped
        step(1, 9'h014, 2'd1, 1, 8'h21, 0, 0, '0);
        step(0, '0, 2'd1, 0, '0, 0, 0, '0);
        check(ctl_q == 9'h014, "R2 ctl_q after enable", ctl_q, 9'h014);
        check(rx_active && tx_active, "R2 both active", {rx_active, tx_active}, 2'b11);

        // R5/R6 each mode, line and host together
        for (int m = 0; m < 4; m++) begin
            step(0, '0, 2'(m), 1, 8'h40 + 8'(m), 0, 1, 8'h80 + 8'(m));
            step(0, '0, 2'(m), 0, '0, 0, 1, 8'hC0 + 8'(m));
            step(0, '0, 2'(m), 1, 8'h50 + 8'(m), 0, 0, '0);
        end

        // R8 break handling
        step(0, '0, 2'd0, 0, '0, 1, 0, '0);
        step(0, '0, 2'd1, 0, '0, 1, 0, '0);
        step(0, '0, 2'd0, 1, 8'h5A, 1, 0, '0);
        step(0, '0, 2'd2, 0, '0, 1, 0, '0);
        step(0, '0, 2'd3, 0, '0, 1, 0, '0);

        // R3 self-clearing resets
        step(1, 9'h017, 2'd0, 0, '0, 0, 0, '0);
        check(ctl_q == 9'h017, "R3 bits visible during pulse", ctl_q, 9'h017);
        step(0, '0, 2'd0, 0, '0, 0, 0, '0);
        check(ctl_q == 9'h014, "R3 bits cleared", ctl_q, 9'h014);
        step(1, 9'h015, 2'd0, 0, '0, 0, 0, '0);
        step(0, '0, 2'd0, 0, '0, 0, 0, '0);

        // R4 break request
        step(1, 9'h094, 2'd0, 0, '0, 0, 0, '0);
        check(brk_req == 1'b1, "R4 start break", brk_req, 1);
        step(1, 9'h194, 2'd0, 0, '0, 0, 0, '0);
        check(brk_req == 1'b0, "R4 stop overrides", brk_req, 0);

        // R7 same cycle: disable written with a byte, byte still routed
        step(1, 9'h03C, 2'd1, 1, 8'h77, 0, 0, '0);
        step(0, '0, 2'd1, 0, '0, 0, 0, '0);
        check(!rx_active && !tx_active, "R2 disable wins", {rx_active, tx_active}, 0);
        step(0, '0, 2'd0, 1, 8'h78, 1, 1, 8'h79);

        // R2/R7: receive only, echo mode
        step(1, 9'h024, 2'd1, 0, '0, 0, 0, '0);
        step(0, '0, 2'd1, 1, 8'h9A, 0, 0, '0);
        check(rx_active && !tx_active, "R2 rx only", {rx_active, tx_active}, 2'b10);
        step(0, '0, 2'd1, 1, 8'h9B, 0, 0, '0);

        idle(3);
        check(q_tx.size() == 0, "R5/R6 missing tx push", q_tx.size(), 0);
        check(q_rx.size() == 0, "R5/R6/R8 missing rx push", q_rx.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule